// File: doc/BRIEF.md
# BCH Factor Remainder Checker

This block checks a received t=8 binary BCH codeword over GF(2^13) for corruption. The codeword arrives as a byte stream: the message bytes first, then the 13 parity bytes. The generator of the code is the product of eight degree-13 minimal polynomials. The block does not divide by the full 104-bit generator. Instead it runs eight small dividers side by side, one for each factor. Each divider keeps the 13-bit remainder of the received polynomial modulo its own factor.

A correct codeword is a multiple of the generator, so it is a multiple of every factor, and all eight remainders end at zero. The shortened code needs no special handling: its implicit leading zeros are never sent, and zeros at the front of a stream do not change a remainder. A downstream decoder can use the eight remainders when it evaluates syndromes. The one-bit error flag is enough to decide whether a page read needs correction.

A one-cycle start pulse opens a codeword. Each byte carries a valid qualifier, and the final parity byte also carries a last flag. One cycle after the last byte, the block raises a done strobe. At that point the remainders and the error flag describe the whole codeword.

Top module: `bch_factor_checker`

## Requirements
- R1: While reset is asserted and after its release, every remainder is zero and both `done` and `err` are low.
- R2: After a codeword, field i of `rem_flat` (bits [13*i+12 : 13*i]) holds the remainder of the received polynomial modulo factor i. The x^13 term is omitted from the field. The factors are 0x201B, 0x22BF, 0x23A3, 0x26B1, 0x274F, 0x2993, 0x3079 and 0x31E1, for i = 0 to 7.
- R3: Bit order: earlier bytes carry higher polynomial degrees, and bit 7 of a byte is its highest degree. So the single byte 0x01 leaves every remainder at 1. The bytes 0x80 then 0x00 leave factor 0 at 0x006C, which is x^15 mod x^13+x^4+x^3+x+1.
- R4: `start` clears all eight remainders. A byte presented in the same cycle as `start` is absorbed onto the cleared state, so a stream restarted mid-codeword gives the result of the new stream alone.
- R5: In a cycle with `in_valid` low, the remainders do not change.
- R6: `done` is high for exactly the one cycle that follows a cycle with `in_valid` and `in_last` both high. It is low at every other time.
- R7: While `done` is high, `err` is 1 exactly when some remainder bit is nonzero. A valid systematic codeword, whose parity is the message times x^104 modulo the generator, gives all-zero remainders and `err` = 0.
- R8: Inverting any single bit of a valid codeword sets `err` to 1 at `done`.
- R9: Zero bytes placed ahead of a codeword leave every remainder and `err` unchanged.
- R10: After `done`, the remainders and `err` hold their values until the next `start` or the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the remainders; may coincide with the first byte |
| in_valid | input | 1 | `in_data` carries a byte this cycle |
| in_data | input | DATA_W | Stream byte, bit 7 is the highest degree |
| in_last | input | 1 | Marks the final parity byte, qualified by `in_valid` |
| rem_flat | output | NUM_FACTORS*13 | Eight 13-bit remainders, factor i in bits [13*i +: 13] |
| done | output | 1 | One-cycle strobe after the last byte |
| err | output | 1 | Codeword corrupted, valid while `done` is high |

## Verification
The bench builds the block with its defaults: eight factors and one byte per beat. Every factor's divider is therefore exercised against the ordering a byte-oriented NAND page uses. The bench forms the full generator by multiplying the eight factors itself and encodes codewords systematically with it. This makes the zero-remainder outcome for clean data and for every single-bit flip directly checkable, from short messages up to a full 512-byte sector with its 4200-bit codeword.

// File: rtl/bchchk_pkg.sv
package bchchk_pkg;

   // Degree of every minimal-polynomial factor of the t=8 generator.
   localparam int FACTOR_DEG  = 13;
   localparam int MAX_FACTORS = 8;

   // Factor i of the generator, with the x^13 term included as bit 13.
   function automatic logic [FACTOR_DEG:0] factor_poly(input int idx);
      logic [FACTOR_DEG:0] p;
      case (idx)
         0:       p = 14'h201B;
         1:       p = 14'h22BF;
         2:       p = 14'h23A3;
         3:       p = 14'h26B1;
         4:       p = 14'h274F;
         5:       p = 14'h2993;
         6:       p = 14'h3079;
         default: p = 14'h31E1;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/bchchk_divider.sv
// One fixed-polynomial remainder register, DATA_W bits absorbed per clock.
module bchchk_divider #(
   parameter int                DEG    = 13,
   parameter int                DATA_W = 8,
   parameter logic [DEG:0]      POLY   = 14'h201B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              absorb,
   input  logic [DATA_W-1:0] din,
   output logic [DEG-1:0]    rem,
   output logic [DEG-1:0]    rem_next
);

   if (POLY[DEG] != 1'b1 || POLY[0] != 1'b1) begin : g_bad_poly
      $error("bchchk_divider: POLY must have degree DEG and a constant term");
   end

   // Long division step: shift each bit in, most significant first.
   function automatic logic [DEG-1:0] fold(input logic [DEG-1:0] r,
                                           input logic [DATA_W-1:0] d);
      logic [DEG-1:0] acc;
      logic           carry;
      acc = r;
      for (int k = DATA_W - 1; k >= 0; k--) begin
         carry = acc[DEG-1];
         acc   = {acc[DEG-2:0], d[k]};
         if (carry) acc = acc ^ POLY[DEG-1:0];
      end
      return acc;
   endfunction

   logic [DEG-1:0] base;

   always_comb begin
      base     = clear ? '0 : rem;
      rem_next = absorb ? fold(base, din) : base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rem <= '0;
      else        rem <= rem_next;
   end

   // R5: without a byte or a clear the remainder holds
   a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!absorb && !clear) |=> $stable(rem));

   // R4: a clear without a byte leaves zero
   a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !absorb) |=> (rem == '0));

   // R9: a zero byte onto a zero remainder keeps it zero
   a_r9_leading_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (absorb && din == '0 && (clear || rem == '0)) |=> (rem == '0));

endmodule

// File: rtl/bchchk_seq.sv
// Completion sequencing: done strobe and registered error flag.
module bchchk_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic in_valid,
   input  logic in_last,
   input  logic any_nz_next,
   output logic clear,
   output logic absorb,
   output logic done,
   output logic err
);

   logic finish;

   always_comb begin
      clear  = start;
      absorb = in_valid;
      finish = in_valid && in_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         err  <= 1'b0;
      end else begin
         done <= finish;
         if (finish)     err <= any_nz_next;
         else if (start) err <= 1'b0;
      end
   end

   // R6: done follows a last byte
   a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> done);

   // R6: done appears only after a last byte
   a_r6_done_only_then: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_last) |=> !done);

   // R10: err holds between completions unless restarted
   a_r10_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!finish && !start) |=> $stable(err));

endmodule

// File: rtl/bch_factor_checker.sv
module bch_factor_checker #(
   parameter int DATA_W      = 8,
   parameter int NUM_FACTORS = bchchk_pkg::MAX_FACTORS,
   parameter int DEG         = bchchk_pkg::FACTOR_DEG,
   localparam int REM_W      = NUM_FACTORS * DEG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic [REM_W-1:0]  rem_flat,
   output logic              done,
   output logic              err
);

   if (DEG != bchchk_pkg::FACTOR_DEG) begin : g_bad_deg
      $error("bch_factor_checker: DEG must match the factor table");
   end
   if (NUM_FACTORS < 1 || NUM_FACTORS > bchchk_pkg::MAX_FACTORS) begin : g_bad_cnt
      $error("bch_factor_checker: NUM_FACTORS out of range");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_w
      $error("bch_factor_checker: DATA_W out of range");
   end

   logic             clear;
   logic             absorb;
   logic             any_nz_next;
   logic [REM_W-1:0] next_flat;

   for (genvar i = 0; i < NUM_FACTORS; i++) begin : g_factor
      bchchk_divider #(
         .DEG   (DEG),
         .DATA_W(DATA_W),
         .POLY  (bchchk_pkg::factor_poly(i))
      ) div_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear   (clear),
         .absorb  (absorb),
         .din     (in_data),
         .rem     (rem_flat[i*DEG +: DEG]),
         .rem_next(next_flat[i*DEG +: DEG])
      );
   end

   assign any_nz_next = |next_flat;

   bchchk_seq seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .any_nz_next(any_nz_next),
      .clear      (clear),
      .absorb     (absorb),
      .done       (done),
      .err        (err)
   );

   // R7: at completion the flag matches the remainder registers
   a_r7_err_matches_rems: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err == (rem_flat != '0)));

   // R10: after completion with no new input the remainders stay put
   a_r10_rems_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !in_valid && !start) |=> $stable(rem_flat));

endmodule

// File: tb/bch_factor_checker_tb_top.sv
module bch_factor_checker_tb_top;

   localparam int NF = 8;
   localparam int DG = 13;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            in_valid = 1'b0;
   logic [7:0]      in_data = '0;
   logic            in_last = 1'b0;
   logic [NF*DG-1:0] rem_flat;
   logic            done;
   logic            err;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   logic [13:0]  fac [NF];
   logic [104:0] gen;
   logic [7:0]   cw [0:599];

   always #10 clk = ~clk;

   bch_factor_checker dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_data(in_data), .in_last(in_last), .rem_flat(rem_flat),
      .done(done), .err(err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [103:0] act, input logic [103:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [12:0] ref_mod(input logic [13:0] f, input int n);
      logic [12:0] a;
      logic        c;
      a = '0;
      for (int i = 0; i < n; i++)
         for (int k = 7; k >= 0; k--) begin
            c = a[12];
            a = {a[11:0], cw[i][k]};
            if (c) a = a ^ f[12:0];
         end
      return a;
   endfunction

   // Systematic encode of cw[0..mlen-1]; parity goes to cw[mlen..mlen+12].
   task automatic encode(input int mlen);
      logic [103:0] r;
      logic         fb;
      r = '0;
      for (int i = 0; i < mlen; i++)
         for (int k = 7; k >= 0; k--) begin
            fb = r[103] ^ cw[i][k];
            r  = {r[102:0], 1'b0};
            if (fb) r = r ^ gen[103:0];
         end
      for (int j = 0; j < 13; j++) cw[mlen + j] = r[103 - 8*j -: 8];
   endtask

   task automatic fill_random(input int n);
      for (int i = 0; i < n; i++) cw[i] = 8'($urandom);
   endtask

   // Streams lead zero bytes then cw[0..n-1]; gap inserts idle cycles.
   task automatic send(input int n, input int lead, input bit gap);
      for (int i = 0; i < n + lead; i++) begin
         @(negedge clk);
         start    = (i == 0);
         in_valid = 1'b1;
         in_data  = (i < lead) ? 8'h00 : cw[i - lead];
         in_last  = (i == n + lead - 1);
         if (gap && i != n + lead - 1) begin
            @(negedge clk);
            start    = 1'b0;
            in_valid = 1'b0;
            in_data  = 8'hA5;
            in_last  = 1'b1;
         end
      end
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
   endtask

   // Called at the negedge right after send: done must be high now.
   task automatic check_result(input int n, input string req);
      logic [NF*DG-1:0] exp;
      for (int f = 0; f < NF; f++) exp[f*DG +: DG] = ref_mod(fac[f], n);
      check(done == 1'b1, "R6", "done after last", 104'(done), 104'd1);
      check(rem_flat == exp, req, "remainders", rem_flat, exp);
      check(err == (exp != '0), "R7", "err flag", 104'(err), 104'(exp != '0));
   endtask

   task automatic t_reset;
      check(rem_flat == '0, "R1", "reset rems", rem_flat, '0);
      check(done == 1'b0 && err == 1'b0, "R1", "reset done/err",
            104'({done, err}), '0);
   endtask

   task automatic t_order;
      cw[0] = 8'h01;
      send(1, 0, 0);
      check_result(1, "R3");
      check(rem_flat == {NF{13'd1}}, "R3", "byte 0x01", rem_flat, {NF{13'd1}});
      cw[0] = 8'h80; cw[1] = 8'h00;
      send(2, 0, 0);
      check(rem_flat[12:0] == 13'h006C, "R3", "x^15 mod factor0",
            104'(rem_flat[12:0]), 104'h6C);
   endtask

   task automatic t_clean(input int mlen, input bit gap);
      fill_random(mlen);
      encode(mlen);
      send(mlen + 13, 0, gap);
      check(rem_flat == '0, "R7", "clean codeword rems", rem_flat, '0);
      check(err == 1'b0, "R7", "clean codeword err", 104'(err), '0);
   endtask

   task automatic t_random_stream(input int n, input bit gap);
      fill_random(n);
      send(n, 0, gap);
      check_result(n, gap ? "R5" : "R2");
   endtask

   task automatic t_flips(input int mlen, input int count);
      int n;
      int p;
      fill_random(mlen);
      encode(mlen);
      n = mlen + 13;
      for (int j = 0; j < count; j++) begin
         p = (j == 0) ? 0 : (j == count - 1) ? n*8 - 1 : int'($urandom % (n*8));
         cw[p/8] = cw[p/8] ^ (8'h80 >> (p % 8));
         send(n, 0, 0);
         check(err == 1'b1, "R8", $sformatf("flip bit %0d", p), 104'(err), 104'd1);
         check_result(n, "R2");
         cw[p/8] = cw[p/8] ^ (8'h80 >> (p % 8));
      end
   endtask

   task automatic t_shortened;
      fill_random(20);
      encode(20);
      send(33, 30, 0);
      check(rem_flat == '0 && err == 1'b0, "R9", "zero prefix clean",
            rem_flat, '0);
      fill_random(17);
      send(17, 9, 0);
      check_result(17, "R9");
   endtask

   task automatic t_restart;
      fill_random(25);
      for (int i = 0; i < 11; i++) begin
         @(negedge clk);
         start = (i == 0); in_valid = 1'b1; in_data = 8'($urandom); in_last = 1'b0;
      end
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0;
      encode(12);
      send(25, 0, 0);
      check(rem_flat == '0 && err == 1'b0, "R4", "restart discards prior bytes",
            rem_flat, '0);
   endtask

   task automatic t_hold;
      logic [NF*DG-1:0] snap;
      logic             esnap;
      fill_random(9);
      send(9, 0, 0);
      snap  = rem_flat;
      esnap = err;
      check(err == 1'b1, "R7", "random stream flagged", 104'(err), 104'd1);
      @(negedge clk);
      check(done == 1'b0, "R6", "done single cycle", 104'(done), '0);
      repeat (5) @(negedge clk);
      check(rem_flat == snap && err == esnap, "R10", "hold after done",
            rem_flat, snap);
      check(done == 1'b0, "R6", "done stays low", 104'(done), '0);
   endtask

   initial begin
      #(20ns * 200000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [104:0] prod;
      fac[0] = 14'h201B; fac[1] = 14'h22BF; fac[2] = 14'h23A3; fac[3] = 14'h26B1;
      fac[4] = 14'h274F; fac[5] = 14'h2993; fac[6] = 14'h3079; fac[7] = 14'h31E1;
      gen = 105'd1;
      for (int f = 0; f < NF; f++) begin
         prod = '0;
         for (int j = 0; j < 14; j++) if (fac[f][j]) prod = prod ^ (gen << j);
         gen = prod;
      end

      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      t_order();
      t_clean(32, 0);
      t_clean(64, 1);
      t_clean(512, 0);
      t_random_stream(40, 0);
      t_random_stream(23, 1);
      t_flips(64, 12);
      t_flips(512, 4);
      t_shortened();
      t_restart();
      t_hold();

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule